// File: doc/BRIEF.md
# Serial Configuration Mesh Router Node

This block is one node of a two-dimensional mesh that delivers configuration data as serial bit streams. A stream arrives on one of four neighbour links (north, east, south, west). Each link carries one data bit and one valid bit per clock. The first four bits of a stream form a header, which the node consumes. The header says whether this node takes a configuration section, whether the stream stops here, and which neighbour receives whatever follows.

When loading is requested, the next 36 bits fill the node's configuration register. This is nine bits for each of four quarters. The new word is presented in parallel, together with a one-cycle done strobe, only once the last of those bits is in. Any bits after that are either passed on to the chosen neighbour one cycle later or dropped, depending on the end flag. A stream ends when its valid signal falls, and the node then waits for a fresh header. A node that is not loading keeps its current configuration and only routes.

Top module: `cfg_mesh_node`

## Requirements
- R1: After reset, all link outputs are low, the configuration word is all zeros and the done strobe is low.
- R2: Header bit order is load flag first, then end flag (1 = stream terminates at this node), then two direction bits, most significant first. The direction encodings are 00 north, 01 east, 10 south, 11 west. Link indices are 0 north, 1 east, 2 south, 3 west. Header bits never appear on any output.
- R3: With the load flag set, the 36 bits after the header are loaded. The first of them lands in cfg_o[35] and the last in cfg_o[0]. Quarter q owns cfg_o[9q+8:9q], laid out as function [3:0], input select [5:4], data latch initial value [6], event latch initial value [7] and join enable [8].
- R4: The done strobe is high for exactly one cycle, the cycle after the 36th configuration bit is taken. cfg_o changes only in that cycle.
- R5: With the load flag clear, the node is bypassed: cfg_o keeps its value and no done strobe occurs.
- R6: With the end flag clear, every bit after the header (and after the configuration section, if any) appears on the selected output link one cycle after it is received, with that link's valid high. All other output links stay idle.
- R7: With the end flag set, bits after the node's own section are discarded and no output link is driven.
- R8: A stream ends when its input valid falls. A stream cut short inside the configuration section leaves cfg_o unchanged and raises no done strobe. A new header is accepted in the very next cycle.
- R9: While idle, the lowest-index link with valid high is taken. While a stream is active, the other links are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | 4 | Per-link input valid, index 0 N, 1 E, 2 S, 3 W |
| in_bit_i | input | 4 | Per-link input data bit |
| out_vld_o | output | 4 | Per-link forwarded valid |
| out_bit_o | output | 4 | Per-link forwarded data bit |
| cfg_o | output | 36 | Parallel configuration word, four 9-bit quarters |
| cfg_done_o | output | 1 | One-cycle strobe when a new configuration is presented |

## Verification
Two things can fall in the same cycle: the completion of a configuration load and the end of its stream. A stream whose last bit is the 36th configuration bit has its valid dropped immediately afterwards. The done strobe must still appear exactly once with the full word, the outputs must stay quiet, and a new header launched the next cycle must be accepted. A second collision, two links raising valid in the same idle cycle, is provoked by holding a higher-index link high throughout a stream. It is judged by checking that only the lower link's bits are forwarded.

// File: rtl/cfg_mesh_pkg.sv
package cfg_mesh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HDR   = 3'd1,
    ST_CFG   = 3'd2,
    ST_FWD   = 3'd3,
    ST_DRAIN = 3'd4
  } node_state_e;

  localparam int unsigned LINK_N = 0;
  localparam int unsigned LINK_E = 1;
  localparam int unsigned LINK_S = 2;
  localparam int unsigned LINK_W = 3;
endpackage

// File: rtl/cfg_port_pick.sv
module cfg_port_pick #(
  parameter int unsigned NPORTS = 4,
  localparam int unsigned IDX_W = $clog2(NPORTS)
) (
  input  logic [NPORTS-1:0] vld_i,
  input  logic [NPORTS-1:0] bit_i,
  input  logic              locked_i,
  input  logic [IDX_W-1:0]  lock_idx_i,
  output logic [IDX_W-1:0]  pick_idx_o,
  output logic              sel_vld_o,
  output logic              sel_bit_o
);
  logic [IDX_W-1:0] idx;

  // lowest index wins
  always_comb begin
    pick_idx_o = '0;
    for (int i = NPORTS - 1; i >= 0; i--) begin
      if (vld_i[i]) pick_idx_o = IDX_W'(i);
    end
  end

  assign idx       = locked_i ? lock_idx_i : pick_idx_o;
  assign sel_vld_o = vld_i[idx];
  assign sel_bit_o = bit_i[idx];
endmodule

// File: rtl/cfg_hdr_ctrl.sv
module cfg_hdr_ctrl
  import cfg_mesh_pkg::*;
#(
  parameter int unsigned CFG_W = 36,
  parameter int unsigned DIR_W = 2,
  localparam int unsigned HDR_W = 2 + DIR_W,
  localparam int unsigned CNT_W = $clog2(CFG_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_vld_i,
  input  logic             sel_bit_i,
  input  logic [DIR_W-1:0] pick_idx_i,
  output logic             locked_o,
  output logic [DIR_W-1:0] lock_idx_o,
  output logic             shift_en_o,
  output logic             last_o,
  output logic             fwd_en_o,
  output logic [DIR_W-1:0] dir_o
);
  node_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             load_q, end_q;
  logic [DIR_W-1:0] dir_q, port_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      load_q  <= 1'b0;
      end_q   <= 1'b0;
      dir_q   <= '0;
      port_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (sel_vld_i) begin
          port_q  <= pick_idx_i;
          load_q  <= sel_bit_i;
          cnt_q   <= CNT_W'(1);
          state_q <= ST_HDR;
        end
        ST_HDR: if (!sel_vld_i) begin
          state_q <= ST_IDLE;
        end else begin
          if (cnt_q == CNT_W'(1)) end_q <= sel_bit_i;
          else dir_q <= (dir_q << 1) | DIR_W'(sel_bit_i);
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(HDR_W - 1)) begin
            cnt_q <= '0;
            if (load_q)     state_q <= ST_CFG;
            else if (end_q) state_q <= ST_DRAIN;
            else            state_q <= ST_FWD;
          end
        end
        ST_CFG: if (!sel_vld_i) begin
          state_q <= ST_IDLE;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          if (last_o) begin
            cnt_q   <= '0;
            state_q <= end_q ? ST_DRAIN : ST_FWD;
          end
        end
        ST_FWD, ST_DRAIN: if (!sel_vld_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign locked_o   = (state_q != ST_IDLE);
  assign lock_idx_o = port_q;
  assign shift_en_o = (state_q == ST_CFG) && sel_vld_i;
  assign last_o     = (cnt_q == CNT_W'(CFG_W - 1));
  assign fwd_en_o   = (state_q == ST_FWD) && sel_vld_i;
  assign dir_o      = dir_q;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CFG) |-> (cnt_q < CNT_W'(CFG_W))); // R3
  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && $past(locked_o)) |-> $stable(lock_idx_o)); // R9
  AST_NO_FWD_WHILE_LOADING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_o |-> !fwd_en_o); // R6
endmodule

// File: rtl/cfg_load_reg.sv
module cfg_load_reg #(
  parameter int unsigned CFG_W = 36
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_en_i,
  input  logic             last_i,
  input  logic             bit_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             done_o
);
  logic [CFG_W-1:0] shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      cfg_o    <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (shift_en_i) begin
        shadow_q <= {shadow_q[CFG_W-2:0], bit_i};
        if (last_i) begin
          cfg_o  <= {shadow_q[CFG_W-2:0], bit_i};
          done_o <= 1'b1;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R4
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(cfg_o)); // R4
endmodule

// File: rtl/cfg_fwd_out.sv
module cfg_fwd_out #(
  parameter int unsigned NPORTS = 4,
  localparam int unsigned IDX_W = $clog2(NPORTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fwd_en_i,
  input  logic [IDX_W-1:0]  dir_i,
  input  logic              bit_i,
  output logic [NPORTS-1:0] out_vld_o,
  output logic [NPORTS-1:0] out_bit_o
);
  for (genvar p = 0; p < NPORTS; p++) begin : g_link
    logic hit;
    assign hit = fwd_en_i && (dir_i == IDX_W'(p));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        out_vld_o[p] <= 1'b0;
        out_bit_o[p] <= 1'b0;
      end else begin
        out_vld_o[p] <= hit;
        out_bit_o[p] <= hit & bit_i;
      end
    end
  end

  AST_FWD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(out_vld_o)); // R6
  AST_BIT_NEEDS_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((out_bit_o & ~out_vld_o) == '0)); // R6
endmodule

// File: rtl/cfg_mesh_node.sv
module cfg_mesh_node #(
  parameter int unsigned NUM_QUARTERS = 4,
  parameter int unsigned QUARTER_W    = 9,
  parameter int unsigned NPORTS       = 4,
  localparam int unsigned CFG_W = NUM_QUARTERS * QUARTER_W,
  localparam int unsigned DIR_W = $clog2(NPORTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPORTS-1:0] in_vld_i,
  input  logic [NPORTS-1:0] in_bit_i,
  output logic [NPORTS-1:0] out_vld_o,
  output logic [NPORTS-1:0] out_bit_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              cfg_done_o
);
  logic             locked, sel_vld, sel_bit, shift_en, last, fwd_en;
  logic [DIR_W-1:0] pick_idx, lock_idx, dir;

  cfg_port_pick #(.NPORTS(NPORTS)) u_pick (
    .vld_i      (in_vld_i),
    .bit_i      (in_bit_i),
    .locked_i   (locked),
    .lock_idx_i (lock_idx),
    .pick_idx_o (pick_idx),
    .sel_vld_o  (sel_vld),
    .sel_bit_o  (sel_bit)
  );

  cfg_hdr_ctrl #(.CFG_W(CFG_W), .DIR_W(DIR_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_vld_i  (sel_vld),
    .sel_bit_i  (sel_bit),
    .pick_idx_i (pick_idx),
    .locked_o   (locked),
    .lock_idx_o (lock_idx),
    .shift_en_o (shift_en),
    .last_o     (last),
    .fwd_en_o   (fwd_en),
    .dir_o      (dir)
  );

  cfg_load_reg #(.CFG_W(CFG_W)) u_load (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (shift_en),
    .last_i     (last),
    .bit_i      (sel_bit),
    .cfg_o      (cfg_o),
    .done_o     (cfg_done_o)
  );

  cfg_fwd_out #(.NPORTS(NPORTS)) u_fwd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fwd_en_i  (fwd_en),
    .dir_i     (dir),
    .bit_i     (sel_bit),
    .out_vld_o (out_vld_o),
    .out_bit_o (out_bit_o)
  );

  AST_FWD_FROM_LIVE_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|out_vld_o) |-> $past(|in_vld_i)); // R6
  AST_DONE_FROM_LIVE_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_done_o |-> $past(|in_vld_i)); // R8
endmodule

// File: tb/cfg_mesh_node_tb.sv
module cfg_mesh_node_tb;
  localparam int CLK_NS = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  in_vld_i = '0, in_bit_i = '0;
  logic [3:0]  out_vld_o, out_bit_o;
  logic [35:0] cfg_o;
  logic        cfg_done_o;

  int errors = 0, checks = 0;
  logic [35:0] exp_cfg = '0;
  bit finished = 0;

  always #(CLK_NS/2) clk_i = ~clk_i;

  cfg_mesh_node u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_vld_i(in_vld_i), .in_bit_i(in_bit_i),
    .out_vld_o(out_vld_o), .out_bit_o(out_bit_o), .cfg_o(cfg_o), .cfg_done_o(cfg_done_o)
  );

  typedef struct packed {
    logic [1:0]  port;
    logic        ld;
    logic        en;
    logic [1:0]  dir;
    logic [35:0] cfg;
    logic [3:0]  nt;
    logic [7:0]  tr;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 1'b1, 1'b0, 2'b01, 36'h9A5C30F1E, 4'd8, 8'hA5},
    '{2'd1, 1'b0, 1'b0, 2'b10, 36'h000000000, 4'd6, 8'h3C},
    '{2'd2, 1'b1, 1'b1, 2'b11, 36'h7FFFF0001, 4'd5, 8'hFF},
    '{2'd3, 1'b0, 1'b1, 2'b00, 36'h000000000, 4'd4, 8'h0F},
    '{2'd3, 1'b1, 1'b0, 2'b00, 36'h123456789, 4'd3, 8'h06},
    '{2'd0, 1'b0, 1'b0, 2'b11, 36'h000000000, 4'd8, 8'h81}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_stream(input int port, input logic ld, input logic en,
                            input logic [1:0] dir, input logic [35:0] cfg,
                            input int nt, input logic [7:0] tr,
                            input logic [3:0] noise, input int cut);
    logic bits [64];
    int n, cfg_end;
    bits[0] = ld; bits[1] = en; bits[2] = dir[1]; bits[3] = dir[0];
    n = 4;
    if (ld) for (int i = 35; i >= 0; i--) begin bits[n] = cfg[i]; n++; end
    cfg_end = n;
    for (int i = 0; i < nt; i++) begin bits[n] = tr[i]; n++; end
    if (cut < n) n = cut;
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      in_vld_i = noise | (4'b1 << port);
      in_bit_i = noise;
      in_bit_i[port] = bits[k];
      @(posedge clk_i); #1;
      if (ld && k == cfg_end - 1) begin
        exp_cfg = cfg;
        check("R4 done after 36th bit", 64'(cfg_done_o), 64'd1);
        check("R3 loaded word", 64'(cfg_o), 64'(exp_cfg));
      end else begin
        check("R4 no done", 64'(cfg_done_o), 64'd0);
        if (!ld) check("R5 bypass keeps cfg", 64'(cfg_o), 64'(exp_cfg));
      end
      if (k >= cfg_end && !en) begin
        check("R6 forward valid", 64'(out_vld_o), 64'(4'b1 << dir));
        check("R6 forward bit", 64'(out_bit_o[dir]), 64'(bits[k]));
      end else if (k >= cfg_end) begin
        check("R7 drained", 64'(out_vld_o), 64'd0);
      end else begin
        check("R2 header/cfg not forwarded", 64'(out_vld_o), 64'd0);
      end
    end
    @(negedge clk_i);
    in_vld_i = '0; in_bit_i = '0;
    @(posedge clk_i); #1;
    check("R8 idle after drop vld", 64'(out_vld_o), 64'd0);
    check("R8 idle after drop done", 64'(cfg_done_o), 64'd0);
    check("R8 cfg held", 64'(cfg_o), 64'(exp_cfg));
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1;
    check("R1 reset out_vld", 64'(out_vld_o), 64'd0);
    check("R1 reset cfg", 64'(cfg_o), 64'd0);
    check("R1 reset done", 64'(cfg_done_o), 64'd0);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check("R1 post reset out_bit", 64'(out_bit_o), 64'd0);

    // table walk: R2 R3 R5 R6 R7 R8
    foreach (VECS[i])
      run_stream(VECS[i].port, VECS[i].ld, VECS[i].en, VECS[i].dir, VECS[i].cfg,
                 VECS[i].nt, VECS[i].tr, 4'b0000, 64);

    // R8: abort inside config section
    run_stream(1, 1'b1, 1'b0, 2'b10, 36'hFFFFFFFFF, 0, 8'h00, 4'b0000, 14);
    // R9: link 3 held high from the same idle cycle; link 1 must win
    run_stream(1, 1'b1, 1'b0, 2'b00, 36'h0AAAA5555, 6, 8'h2D, 4'b1000, 64);
    // R9: links 2 and 3 noisy, link 0 bypass forward
    run_stream(0, 1'b0, 1'b0, 2'b01, 36'h0, 5, 8'h15, 4'b1100, 64);
    // R4 R8: load ends with the stream, back-to-back next header
    run_stream(2, 1'b1, 1'b0, 2'b11, 36'hC3C3C3C3C, 0, 8'h00, 4'b0000, 64);
    run_stream(3, 1'b0, 1'b0, 2'b10, 36'h0, 4, 8'h09, 4'b0000, 64);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule